// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block sits next to one processor and keeps the state of 256 interrupt vectors. A delivery source hands it one vector per cycle along with that vector's trigger mode. The controller records the vector as pending and, on the processor side, decides whether the processor's interrupt line should be raised. The decision uses priority classes. A vector's class is its top four bits. The controller derives a processor priority from a software-written task priority and from the highest vector currently in service. A pending request raises the line only when its class is above the class of that processor priority.

The processor takes an interrupt by pulsing an acknowledge strobe. One cycle later the controller returns one of three results: a granted vector (with its trigger mode), the spurious vector, or a no-interrupt flag. A granted vector moves from pending to in service. An end-of-interrupt strobe retires the highest vector in service. A small register port gives access to the task priority and the spurious-vector register (bit 8 is the software enable), and a read-only view of the processor priority.

The vector-accept port is a valid/ready stream. `acc_ready` is held high at all times: the bitmaps absorb one vector on every cycle, so a source never stalls. The acknowledge response is a single-cycle `ack_valid` pulse and takes no back-pressure. The interrupt line and the register port are plain signals.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A vector presented with `acc_valid` sets its pending bit and records its trigger mode: `acc_level`=1 (level) sets the mode bit and 0 (edge) clears it. A later grant of that vector reports the recorded mode on `ack_level`.
- R2: After reset, the task priority (select 0) reads 0, the spurious register (select 1) reads 0x0FF, the processor priority (select 2) reads 0, `irq` is low, and no vector is pending or in service.
- R3: Register select 0 writes `reg_wdata[7:0]` to the task priority. Select 1 writes `reg_wdata[8:0]` to the spurious register and drops all higher bits. Writes to selects 2 and 3 change nothing, and select 3 reads 0.
- R4: The processor priority equals the task priority when the task class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that in-service class followed by four zero bits. An empty in-service set counts as class 0.
- R5: `irq` is high only when spurious bit 8 is set and at least one vector is pending.
- R6: `irq` is also low when the processor priority is nonzero and the class of the highest pending vector is less than or equal to the processor priority class.
- R7: Every `ack_req` cycle yields `ack_valid` in the next cycle and in no other cycle. A grant (`ack_kind`=1) returns the highest pending vector, clears its pending bit and sets its in-service bit.
- R8: If the task priority is nonzero and the highest pending vector is numerically less than or equal to it, the acknowledge returns `ack_kind`=2 with `ack_vec` equal to the spurious register bits 7:0 and `ack_level`=0, and all bitmaps stay unchanged.
- R9: An acknowledge when bit 8 of the spurious register is clear or nothing is pending returns `ack_kind`=0 with `ack_vec`=0 and changes no state.
- R10: `eoi` clears the highest set in-service bit. With nothing in service it has no effect.
- R11: Events in the same cycle all act on the state from before the edge. An accepted vector is set after a grant clears its pending bit, so the vector stays pending. A grant's in-service set wins over an end-of-interrupt clear of the same bit.
- R12: `acc_ready` is always high. `irq` and `reg_rdata` follow the registered state combinationally, so they show an update in the cycle after the edge that made it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Vector-accept stream valid |
| acc_ready | output | 1 | Vector-accept stream ready, always 1 |
| acc_vec | input | 8 | Vector being delivered |
| acc_level | input | 1 | Trigger mode of the delivered vector, 1 = level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 task priority, 1 spurious, 2 processor priority, 3 reserved |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read of the selected register |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| ack_valid | output | 1 | Acknowledge result valid, one cycle after `ack_req` |
| ack_kind | output | 2 | 0 none, 1 granted, 2 spurious |
| ack_vec | output | 8 | Returned vector |
| ack_level | output | 1 | Trigger mode of a granted vector |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Interrupt line to the processor |

## Verification
The bench targets the class boundary. A pending vector in the same class as the processor priority must keep the line low. A design that compares full vectors instead of classes would raise it. The acknowledge boundary where the pending vector equals the task priority must give the spurious vector, and an off-by-one there would grant it and lose it into service. Retiring interrupts in nested order tests that the processor priority falls back to the next in-service class and then to the task priority. A design that cleared the lowest in-service bit would leave the priority stuck high. Random traffic with collisions, such as accept and grant of the same vector and grant together with end-of-interrupt, exposes a wrong precedence as a lost or duplicated pending bit.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Result of an acknowledge (encodings are part of R7, R8 and R9)
  typedef enum logic [1:0] {
    ACK_NONE  = 2'd0,
    ACK_GRANT = 2'd1,
    ACK_SPUR  = 2'd2
  } ack_kind_e;

  // Register select codes (R3)
  typedef enum logic [1:0] {
    SEL_TASK = 2'd0,
    SEL_SPUR = 2'd1,
    SEL_PROC = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/hi_vec_finder.sv
// Returns the index of the highest set bit of a wide vector.
// Each word is encoded on its own, then the highest non-empty word is chosen.
module hi_vec_finder #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic [NUM_VEC-1:0]         bits,
  output logic                       found,
  output logic [$clog2(NUM_VEC)-1:0] idx
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int WSEL_W    = $clog2(NUM_WORDS);

  function automatic logic [BIT_W-1:0] top_bit(input logic [WORD_W-1:0] w);
    logic [BIT_W-1:0] pos;
    pos = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (w[b]) pos = BIT_W'(b);
    end
    return pos;
  endfunction

  logic [NUM_WORDS-1:0]            word_any;
  logic [NUM_WORDS-1:0][BIT_W-1:0] word_pos;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_any[w] = |bits[w*WORD_W +: WORD_W];
    assign word_pos[w] = top_bit(bits[w*WORD_W +: WORD_W]);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_any[w]) begin
        found = 1'b1;
        idx   = {WSEL_W'(w), word_pos[w]};
      end
    end
  end
endmodule

// File: rtl/vec_state.sv
// Pending, in-service and trigger-mode bitmaps, one register bank per word.
module vec_state #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_set,
  input  logic [$clog2(NUM_VEC)-1:0] acc_vec,
  input  logic                       acc_level,
  input  logic                       grant,
  input  logic [$clog2(NUM_VEC)-1:0] grant_vec,
  input  logic                       retire,
  input  logic [$clog2(NUM_VEC)-1:0] retire_vec,
  output logic [NUM_VEC-1:0]         pend,
  output logic [NUM_VEC-1:0]         serv,
  output logic                       grant_level
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int VEC_W     = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] mode;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_bank
    logic [WORD_W-1:0] pend_q, serv_q, mode_q;
    logic [WORD_W-1:0] acc_m, grant_m, retire_m;

    always_comb begin
      acc_m    = '0;
      grant_m  = '0;
      retire_m = '0;
      if (acc_set && (acc_vec[VEC_W-1:BIT_W] == (VEC_W-BIT_W)'(w)))
        acc_m[acc_vec[BIT_W-1:0]] = 1'b1;
      if (grant && (grant_vec[VEC_W-1:BIT_W] == (VEC_W-BIT_W)'(w)))
        grant_m[grant_vec[BIT_W-1:0]] = 1'b1;
      if (retire && (retire_vec[VEC_W-1:BIT_W] == (VEC_W-BIT_W)'(w)))
        retire_m[retire_vec[BIT_W-1:0]] = 1'b1;
    end

    // R11: accept set after grant clear; grant set after retire clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        serv_q <= '0;
        mode_q <= '0;
      end else begin
        pend_q <= (pend_q & ~grant_m) | acc_m;
        serv_q <= (serv_q & ~retire_m) | grant_m;
        mode_q <= acc_level ? (mode_q | acc_m) : (mode_q & ~acc_m); // R1
      end
    end

    assign pend[w*WORD_W +: WORD_W] = pend_q;
    assign serv[w*WORD_W +: WORD_W] = serv_q;
    assign mode[w*WORD_W +: WORD_W] = mode_q;
  end

  assign grant_level = mode[grant_vec];
endmodule

// File: rtl/prio_gate.sv
// Processor priority, interrupt line and acknowledge decision.
module prio_gate
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic [VEC_W-1:0] task_pri,
  input  logic             enable,
  input  logic             pend_found,
  input  logic [VEC_W-1:0] pend_hi,
  input  logic             serv_found,
  input  logic [VEC_W-1:0] serv_hi,
  output logic [VEC_W-1:0] proc_pri,
  output logic             irq_line,
  output ack_kind_e        decision
);
  localparam int SUB_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] task_cls, serv_cls, pend_cls, proc_cls;

  assign task_cls = task_pri[VEC_W-1:SUB_W];
  assign serv_cls = serv_found ? serv_hi[VEC_W-1:SUB_W] : '0;
  assign pend_cls = pend_hi[VEC_W-1:SUB_W];

  // R4
  assign proc_pri = (task_cls >= serv_cls) ? task_pri : {serv_cls, {SUB_W{1'b0}}};
  assign proc_cls = proc_pri[VEC_W-1:SUB_W];

  // R5, R6
  assign irq_line = enable && pend_found &&
                    !((proc_pri != '0) && (pend_cls <= proc_cls));

  // R7, R8, R9
  always_comb begin
    if (!enable || !pend_found)
      decision = ACK_NONE;
    else if ((task_pri != '0) && (pend_hi <= task_pri))
      decision = ACK_SPUR;
    else
      decision = ACK_GRANT;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int DATA_W  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  output logic        acc_ready,
  input  logic [7:0]  acc_vec,
  input  logic        acc_level,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ack_req,
  output logic        ack_valid,
  output logic [1:0]  ack_kind,
  output logic [7:0]  ack_vec,
  output logic        ack_level,
  input  logic        eoi,
  output logic        irq
);
  localparam int VEC_W   = $clog2(NUM_VEC);
  localparam int SPUR_W  = VEC_W + 1;
  localparam logic [SPUR_W-1:0] SPUR_RST = {1'b0, {VEC_W{1'b1}}};

  logic [VEC_W-1:0]  tpr_q;
  logic [SPUR_W-1:0] spur_q;
  logic [NUM_VEC-1:0] pend, serv;
  logic pend_found, serv_found, grant_level, irq_line;
  logic [VEC_W-1:0] pend_hi, serv_hi, proc_pri;
  ack_kind_e decision;
  logic grant, retire;

  assign acc_ready = 1'b1; // R12: never back-pressures

  assign grant  = ack_req && (decision == ACK_GRANT);
  assign retire = eoi && serv_found; // R10

  hi_vec_finder #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_pend_find (
    .bits(pend), .found(pend_found), .idx(pend_hi)
  );

  hi_vec_finder #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_serv_find (
    .bits(serv), .found(serv_found), .idx(serv_hi)
  );

  vec_state #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .acc_set(acc_valid && acc_ready), .acc_vec(acc_vec), .acc_level(acc_level),
    .grant(grant), .grant_vec(pend_hi),
    .retire(retire), .retire_vec(serv_hi),
    .pend(pend), .serv(serv), .grant_level(grant_level)
  );

  prio_gate #(.VEC_W(VEC_W), .CLS_W(4)) u_gate (
    .task_pri(tpr_q), .enable(spur_q[VEC_W]),
    .pend_found(pend_found), .pend_hi(pend_hi),
    .serv_found(serv_found), .serv_hi(serv_hi),
    .proc_pri(proc_pri), .irq_line(irq_line), .decision(decision)
  );

  assign irq = irq_line;

  // Software registers (R2, R3)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q  <= '0;
      spur_q <= SPUR_RST;
    end else if (reg_wr) begin
      case (reg_sel_e'(reg_sel))
        SEL_TASK: tpr_q  <= reg_wdata[VEC_W-1:0];
        SEL_SPUR: spur_q <= reg_wdata[SPUR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_TASK: reg_rdata = DATA_W'(tpr_q);
      SEL_SPUR: reg_rdata = DATA_W'(spur_q);
      SEL_PROC: reg_rdata = DATA_W'(proc_pri);
      default:  reg_rdata = '0;
    endcase
  end

  // Acknowledge response, one cycle after the strobe (R7, R8, R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_kind  <= ACK_NONE;
      ack_vec   <= '0;
      ack_level <= 1'b0;
    end else begin
      ack_valid <= ack_req;
      ack_kind  <= ack_req ? decision : ACK_NONE;
      case (decision)
        ACK_GRANT: begin ack_vec <= pend_hi;               ack_level <= grant_level; end
        ACK_SPUR:  begin ack_vec <= spur_q[VEC_W-1:0];     ack_level <= 1'b0;        end
        default:   begin ack_vec <= '0;                    ack_level <= 1'b0;        end
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [8:0]  spur,
  input logic [7:0]  tpr,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        ack_req,
  input logic        ack_valid,
  input logic [1:0]  ack_kind,
  input logic [7:0]  ack_vec
);
  p_irq_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> spur[8]);

  p_ack_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);

  p_no_stray_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_valid);

  p_spur_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_kind == 2'd2) |-> (ack_vec == $past(spur[7:0])));

  p_grant_above_tpr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_kind == 2'd1 && $past(tpr) != 8'd0) |-> (ack_vec > $past(tpr)));

  p_disabled_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !spur[8]) |=> (ack_kind == 2'd0));

  p_spur_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1) |=> (spur == $past(reg_wdata[8:0])));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .spur(spur_q), .tpr(tpr_q),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .ack_req(ack_req), .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_vec(ack_vec)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_level = 0, reg_wr = 0, ack_req = 0, eoi = 0;
  logic [7:0] acc_vec = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic acc_ready, ack_valid, ack_level, irq;
  logic [1:0] ack_kind;
  logic [7:0] ack_vec;
  logic [31:0] reg_rdata;

  always #5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_vec(acc_vec), .acc_level(acc_level), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_req(ack_req),
    .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_vec(ack_vec),
    .ack_level(ack_level), .eoi(eoi), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [255:0] m_pend, m_serv, m_mode;
  int m_tpr, m_spur;
  bit m_av; int m_ak, m_avec, m_alvl;

  function automatic int hi(bit [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int s = hi(m_serv);
    int sc = (s < 0) ? 0 : (s >> 4);
    return ((m_tpr >> 4) >= sc) ? m_tpr : (sc << 4);
  endfunction

  function automatic int m_irq();
    int h = hi(m_pend);
    int p = m_ppr();
    if (!m_spur[8] || h < 0) return 0;
    if (p != 0 && (h >> 4) <= (p >> 4)) return 0;
    return 1;
  endfunction

  function automatic int m_rd(int sel);
    case (sel)
      0: return m_tpr;
      1: return m_spur;
      2: return m_ppr();
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_serv = '0; m_mode = '0;
      m_tpr = 0; m_spur = 'h0FF; m_av = 0; m_ak = 0; m_avec = 0; m_alvl = 0;
    end else begin
      int h, hs; bit g;
      h = hi(m_pend); hs = hi(m_serv); g = 0;
      m_av = ack_req; m_ak = 0; m_avec = 0; m_alvl = 0;
      if (ack_req) begin
        if (!m_spur[8] || h < 0) m_ak = 0;
        else if (m_tpr != 0 && h <= m_tpr) begin m_ak = 2; m_avec = m_spur & 'hFF; end
        else begin m_ak = 1; m_avec = h; m_alvl = m_mode[h]; g = 1; end
      end
      if (eoi && hs >= 0) m_serv[hs] = 0;
      if (g) begin m_serv[h] = 1; m_pend[h] = 0; end
      if (acc_valid) begin m_pend[acc_vec] = 1; m_mode[acc_vec] = acc_level; end
      if (reg_wr && reg_sel == 0) m_tpr = reg_wdata & 'hFF;
      if (reg_wr && reg_sel == 1) m_spur = reg_wdata & 'h1FF;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 R6 irq", irq, m_irq());
      chk("R3 R4 rdata", reg_rdata, m_rd(reg_sel));
      chk("R12 acc_ready", acc_ready, 1);
      chk("R7 ack_valid", ack_valid, m_av);
      if (m_av) begin
        chk("R7 R8 R9 ack_kind", ack_kind, m_ak);
        chk("R7 R8 R9 ack_vec", ack_vec, m_avec);
        chk("R1 ack_level", ack_level, m_alvl);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic quiet();
    acc_valid = 0; reg_wr = 0; ack_req = 0; eoi = 0;
  endtask
  task automatic put(int v, bit lvl);
    acc_valid = 1; acc_vec = v[7:0]; acc_level = lvl; cyc(); quiet();
  endtask
  task automatic wr(int sel, int d);
    reg_wr = 1; reg_sel = sel[1:0]; reg_wdata = d; cyc(); quiet();
  endtask
  task automatic ack(); ack_req = 1; cyc(); quiet(); endtask
  task automatic end_int(); eoi = 1; cyc(); quiet(); endtask
  task automatic rd(string req, int sel, int exp);
    reg_sel = sel[1:0]; #1; chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    // R2 reset state
    rd("R2 tpr", 0, 0); rd("R2 spur", 1, 'h0FF); rd("R2 ppr", 2, 0);
    chk("R2 irq", irq, 0);
    ack(); chk("R9 empty ack", ack_kind, 0);
    // R5 disabled: pending but line low, ack gives none
    put('h41, 0);
    chk("R5 disabled irq", irq, 0);
    ack(); chk("R9 disabled ack", ack_kind, 0);
    // R3 masking and ignored writes
    wr(1, 'hABCD_E1F3); rd("R3 spur mask", 1, 'h1F3);
    wr(0, 'h1234_5620); rd("R3 tpr mask", 0, 'h20);
    wr(2, 'h77); rd("R3 ppr write ignored", 2, 'h20);
    wr(3, 'h55); rd("R3 rsvd reads 0", 3, 0);
    chk("R5 enabled irq", irq, 1);
    ack(); chk("R7 grant kind", ack_kind, 1); chk("R7 grant vec", ack_vec, 'h41);
    chk("R1 edge mode", ack_level, 0);
    rd("R4 ppr from service", 2, 'h40); chk("R12 irq drop", irq, 0);
    // R6 same-class request held off
    put('h45, 1); chk("R6 same class", irq, 0);
    put('h90, 0); chk("R6 higher class", irq, 1);
    ack(); chk("R7 nested vec", ack_vec, 'h90); rd("R4 nested ppr", 2, 'h90);
    end_int(); rd("R10 eoi top", 2, 'h40);
    end_int(); rd("R10 eoi back to tpr", 2, 'h20);
    ack(); chk("R1 level mode", ack_level, 1); chk("R7 vec 45", ack_vec, 'h45);
    end_int(); end_int(); rd("R10 empty eoi", 2, 'h20);
    // R8 spurious when at or below task priority
    wr(0, 'h50); put('h50, 0);
    ack(); chk("R8 spur kind", ack_kind, 2); chk("R8 spur vec", ack_vec, 'hF3);
    chk("R8 spur level", ack_level, 0);
    wr(0, 'h00);
    ack(); chk("R8 request kept", ack_vec, 'h50); end_int();
    // R11 accept of the vector being granted keeps it pending
    put('h60, 0);
    ack_req = 1; acc_valid = 1; acc_vec = 'h60; acc_level = 1; cyc(); quiet();
    chk("R11 grant vec", ack_vec, 'h60);
    end_int();
    ack(); chk("R11 still pending", ack_vec, 'h60); chk("R11 level kept", ack_level, 1);
    end_int();
    // Random traffic with collisions
    for (int i = 0; i < 4000; i++) begin
      acc_valid = ($urandom % 3) == 0;
      acc_vec   = $urandom;
      acc_level = $urandom;
      ack_req   = ($urandom % 4) == 0;
      eoi       = ($urandom % 5) == 0;
      reg_sel   = $urandom;
      reg_wr    = ($urandom % 25) == 0;
      reg_wdata = (reg_sel == 1) ? ($urandom | (($urandom % 8) != 0 ? 'h100 : 0))
                                 : ($urandom % 160);
      cyc();
    end
    quiet(); cyc(); cyc();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule